// File: doc/BRIEF.md
# Dual-Bank Serial LED Driver Core

This core controls a 24-channel constant-current LED driver. The channels form 8 columns, and each column has a red, a green and a blue channel. A host loads two kinds of per-channel data over a single serial line with a data clock. The first is a 6-bit correction value. The second is an 8-bit grayscale value. A bank-select pin steers each clocked bit into one of two shift chains. The bit that leaves the selected chain is driven on a serial-out pin, so that several devices can be daisy-chained on one line.

A falling edge on the active-low latch pin copies the grayscale chain into a set of output registers. The shift chains keep accepting data without disturbing those registers. Each presented channel level is the latched grayscale value weighted by the channel's correction value. The active-low output enable pin blanks all levels without waiting for a clock edge. The active-low reset pin clears all stored state.

A faster system clock samples the serial-side pins through two-stage synchronizers and detects their edges. The host interface can therefore run asynchronously to the core clock. The physical current sinks and the pulse-width stage that follow the presented levels are outside this block.

Top module: `led_drv_core`

## Requirements
- R1: While `chip_rst_n` (or the system reset `rst_n`) is low, both shift chains and the latched registers clear to zero and `ser_out` is driven low.
- R2: The chains change only on a rising edge of `dclk` as seen after synchronization. Changes of `ser_in` or `bank_sel` while `dclk` holds a level have no effect on the chains or on `ser_out`.
- R3: On a `dclk` rising edge, the chain chosen by `bank_sel` (0 selects correction, 1 selects grayscale) shifts up by one bit and takes `ser_in` into bit 0. The other chain keeps its value.
- R4: On each `dclk` rising edge, `ser_out` is loaded with the selected chain's top bit as it was before the shift. For the correction chain that is bit 143, and for the grayscale chain it is bit 191.
- R5: Channel n holds its grayscale value at bits 8n+7..8n of the grayscale chain and its correction value at bits 6n+5..6n of the correction chain. Correction fields may therefore straddle a 64-bit boundary (channel 10 uses bits 65..60). Channel n is presented at `level[8n+7:8n]`.
- R6: A falling edge of `latch_n` copies the whole grayscale chain into the latched registers. Without a falling edge the latched values hold, even while the chains shift.
- R7: If a `latch_n` falling edge and a `dclk` rising edge are detected in the same core cycle, the latched values are the grayscale chain from before that shift.
- R8: While `out_en_n` is high, every presented level is zero. The pin acts combinationally, without waiting for a clock edge.
- R9: While `out_en_n` is low, each presented level equals (latched gray × (correction + 1)) >> 6, using the channel's current correction value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core system clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| ser_in | input | 1 | Serial data in, asynchronous |
| dclk | input | 1 | Serial data clock, asynchronous |
| chip_rst_n | input | 1 | Active-low reset pin, asynchronous |
| latch_n | input | 1 | Active-low latch pin; a falling edge copies gray data |
| bank_sel | input | 1 | Chain select: 0 correction, 1 grayscale |
| out_en_n | input | 1 | Active-low output enable, combinational |
| ser_out | output | 1 | Serial data out for daisy-chaining |
| level | output | 192 | Presented levels, 8 bits per channel, channel n at [8n+7:8n] |

## Verification
A latch falling edge and a data-clock rising edge can land in the same core cycle. When that happens, the latch must capture the grayscale chain as it stood before the shift. The bench provokes this by driving `latch_n` low and `dclk` high at the same instant, so both pins pass through the synchronizer together. It then compares the presented levels with the pre-shift grayscale contents of its own model. A second case shifts the correction chain while the latched levels are being shown, which confirms that the shift alters only the correction weighting.

// File: rtl/led_drv_pkg.sv
// Package: shared dimensions of the dual-bank LED driver core.
// Assumes: every block of the core takes its defaults from here.
package led_drv_pkg;
    localparam int NUM_COL  = 8;               // matrix columns
    localparam int NUM_CLR  = 3;               // colour channels per column
    localparam int NUM_CH   = NUM_COL * NUM_CLR;
    localparam int GRAY_W   = 8;               // grayscale bits per channel
    localparam int CORR_W   = 6;               // correction bits per channel
    localparam int SYNC_LEN = 2;               // synchronizer stages
endpackage

// File: rtl/pin_sync.sv
// Module: multi-bit synchronizer for asynchronous pins.
// Assumes: every bit is an independent level; bits that change together
// reach the output on the same cycle because all stages share one clock.
module pin_sync #(
    parameter int          W      = 1,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_V = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Purpose: move pin levels through the synchronizer stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_V;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/shift_chain.sv
// Module: one serial shift chain; shifts up with the new bit entering at bit 0.
// Assumes: clr has priority over shift; the parent picks which chain shifts.
module shift_chain #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             shift,
    input  logic             din,
    output logic [WIDTH-1:0] chain
);
    // Purpose: clear, or shift one bit in from the bottom.
    always_ff @(posedge clk) begin
        if (!rst_n)     chain <= '0;
        else if (clr)   chain <= '0;
        else if (shift) chain <= {chain[WIDTH-2:0], din};
    end
endmodule

// File: rtl/led_out_stage.sv
// Module: latched grayscale registers plus per-channel correction weighting.
// Assumes: gray and correction vectors are packed channel 0 at the bottom;
// oe_n is an asynchronous pin that gates the levels combinationally.
module led_out_stage #(
    parameter int NUM_CH = 24,
    parameter int GRAY_W = 8,
    parameter int CORR_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     load,
    input  logic [NUM_CH*GRAY_W-1:0] gray_in,
    input  logic [NUM_CH*CORR_W-1:0] corr_in,
    input  logic                     oe_n,
    output logic [NUM_CH*GRAY_W-1:0] latched,
    output logic [NUM_CH*GRAY_W-1:0] level
);
    localparam int PW = GRAY_W + CORR_W + 1;

    // Purpose: hold the grayscale snapshot taken on each latch event.
    always_ff @(posedge clk) begin
        if (!rst_n)    latched <= '0;
        else if (clr)  latched <= '0;
        else if (load) latched <= gray_in;
    end

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic [GRAY_W-1:0] gray;
        logic [CORR_W-1:0] corr;
        logic [PW-1:0]     prod;

        assign gray = latched[n*GRAY_W +: GRAY_W];
        assign corr = corr_in[n*CORR_W +: CORR_W];

        // Purpose: weight gray by (corr+1)/2^CORR_W and blank on disable.
        always_comb begin
            prod = {{(PW-GRAY_W){1'b0}}, gray} *
                   ({{(PW-CORR_W){1'b0}}, corr} + PW'(1));
            level[n*GRAY_W +: GRAY_W] = oe_n ? '0 : prod[CORR_W +: GRAY_W];
        end
    end
endmodule

// File: rtl/led_drv_core.sv
// Module: top of the dual-bank serial LED driver core.
// Assumes: serial-side pins are asynchronous to clk and slow enough that
// each level is held for more than three clk cycles.
module led_drv_core
    import led_drv_pkg::*;
#(
    parameter int NUM_CH = led_drv_pkg::NUM_CH,
    parameter int GRAY_W = led_drv_pkg::GRAY_W,
    parameter int CORR_W = led_drv_pkg::CORR_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_in,
    input  logic                     dclk,
    input  logic                     chip_rst_n,
    input  logic                     latch_n,
    input  logic                     bank_sel,
    input  logic                     out_en_n,
    output logic                     ser_out,
    output logic [NUM_CH*GRAY_W-1:0] level
);
    localparam int B0W = NUM_CH * CORR_W;
    localparam int B1W = NUM_CH * GRAY_W;

    logic [4:0]     pins_s;
    logic           dclk_s, prst_s, latch_s, sin_s, bsel_s;
    logic           dclk_q, latch_q;
    logic           dclk_rise, latch_fall, clr;
    logic [B0W-1:0] bank0_q;
    logic [B1W-1:0] bank1_q;
    logic [B1W-1:0] latched_w;

    // Reset values: dclk low, pin reset asserted, latch idle high.
    pin_sync #(.W(5), .STAGES(SYNC_LEN), .RST_V(5'b00100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({bank_sel, ser_in, latch_n, chip_rst_n, dclk}),
        .q     (pins_s)
    );
    assign {bsel_s, sin_s, latch_s, prst_s, dclk_s} = pins_s;

    // Purpose: remember last synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dclk_q  <= 1'b0;
            latch_q <= 1'b1;
        end else begin
            dclk_q  <= dclk_s;
            latch_q <= latch_s;
        end
    end

    assign dclk_rise  = dclk_s & ~dclk_q;
    assign latch_fall = ~latch_s & latch_q;
    assign clr        = ~prst_s;

    shift_chain #(.WIDTH(B0W)) u_bank0 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .shift (dclk_rise & ~bsel_s),
        .din   (sin_s),
        .chain (bank0_q)
    );

    shift_chain #(.WIDTH(B1W)) u_bank1 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .shift (dclk_rise & bsel_s),
        .din   (sin_s),
        .chain (bank1_q)
    );

    // Purpose: drive the outgoing top bit of the selected chain.
    always_ff @(posedge clk) begin
        if (!rst_n)         ser_out <= 1'b0;
        else if (clr)       ser_out <= 1'b0;
        else if (dclk_rise) ser_out <= bsel_s ? bank1_q[B1W-1] : bank0_q[B0W-1];
    end

    led_out_stage #(.NUM_CH(NUM_CH), .GRAY_W(GRAY_W), .CORR_W(CORR_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .load    (latch_fall),
        .gray_in (bank1_q),
        .corr_in (bank0_q),
        .oe_n    (out_en_n),
        .latched (latched_w),
        .level   (level)
    );
endmodule

// File: rtl/led_drv_chk.sv
// Module: property checker for led_drv_core, attached by bind.
// Assumes: it observes only; every signal arrives from the top's scope.
module led_drv_chk #(
    parameter int B0W = 144,
    parameter int B1W = 192
) (
    input logic           clk,
    input logic           rst_n,
    input logic           prst_s,
    input logic           bsel_s,
    input logic           dclk_rise,
    input logic           latch_fall,
    input logic           out_en_n,
    input logic           ser_out,
    input logic [B0W-1:0] bank0_q,
    input logic [B1W-1:0] bank1_q,
    input logic [B1W-1:0] latched_w,
    input logic [B1W-1:0] level
);
    AST_PIN_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !prst_s |=> (!ser_out && latched_w == '0 && bank1_q == '0)); // R1
    AST_NO_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_s && !dclk_rise) |=> ($stable(bank0_q) && $stable(bank1_q))); // R2
    AST_UNSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_s && dclk_rise && !bsel_s) |=> $stable(bank1_q)); // R3
    AST_SEROUT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_s && dclk_rise && bsel_s) |=> ser_out == $past(bank1_q[B1W-1])); // R4
    AST_SEROUT_TOP0: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_s && dclk_rise && !bsel_s) |=> ser_out == $past(bank0_q[B0W-1])); // R4
    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_s && !latch_fall) |=> $stable(latched_w)); // R6
    AST_LATCH_PRESHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (prst_s && latch_fall) |=> latched_w == $past(bank1_q)); // R7
    AST_OE_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> level == '0); // R8
endmodule

bind led_drv_core led_drv_chk #(.B0W(B0W), .B1W(B1W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .prst_s     (prst_s),
    .bsel_s     (bsel_s),
    .dclk_rise  (dclk_rise),
    .latch_fall (latch_fall),
    .out_en_n   (out_en_n),
    .ser_out    (ser_out),
    .bank0_q    (bank0_q),
    .bank1_q    (bank1_q),
    .latched_w  (latched_w),
    .level      (level)
);

// File: tb/test_led_drv_core.sv
// Bench: directed scenarios for led_drv_core, each task checking itself.
module test_led_drv_core;
    localparam int NCH = 24;
    localparam int GW  = 8;
    localparam int CW  = 6;
    localparam int B0W = NCH * CW;
    localparam int B1W = NCH * GW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0, dclk = 1'b0, chip_rst_n = 1'b1;
    logic latch_n = 1'b1, bank_sel = 1'b0, out_en_n = 1'b0;
    logic ser_out;
    logic [B1W-1:0] level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the device state.
    logic [B0W-1:0] m_b0 = '0;
    logic [B1W-1:0] m_b1 = '0;
    logic [B1W-1:0] m_lat = '0;
    logic m_sout = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    led_drv_core i_led_drv_core (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .dclk(dclk),
        .chip_rst_n(chip_rst_n), .latch_n(latch_n), .bank_sel(bank_sel),
        .out_en_n(out_en_n), .ser_out(ser_out), .level(level)
    );

    task automatic chk(input string tag, input logic [B1W-1:0] act,
                       input logic [B1W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [B1W-1:0] exp_level();
        logic [B1W-1:0] r;
        for (int n = 0; n < NCH; n++) begin
            int g, c;
            g = int'(m_lat[n*GW +: GW]);
            c = int'(m_b0[n*CW +: CW]);
            r[n*GW +: GW] = GW'((g * (c + 1)) >> 6);
        end
        return r;
    endfunction

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    // One data-clock cycle; model follows R3/R4.
    task automatic shift_bit(input logic bank, input logic b);
        ser_in = b; bank_sel = bank; dclk = 1'b1;
        m_sout = bank ? m_b1[B1W-1] : m_b0[B0W-1];
        if (bank) m_b1 = {m_b1[B1W-2:0], b};
        else      m_b0 = {m_b0[B0W-2:0], b};
        settle();
        dclk = 1'b0;
        settle();
    endtask

    task automatic load1(input logic [B1W-1:0] v);
        for (int i = B1W-1; i >= 0; i--) shift_bit(1'b1, v[i]);
    endtask

    task automatic load0(input logic [B0W-1:0] v);
        for (int i = B0W-1; i >= 0; i--) shift_bit(1'b0, v[i]);
    endtask

    task automatic pulse_latch();
        latch_n = 1'b0; m_lat = m_b1;
        settle();
        latch_n = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        chk("R1 reset ser_out", B1W'(ser_out), '0);
        chk("R1 reset levels", level, '0);
    endtask

    task automatic t_load_latch();
        logic [B1W-1:0] g;
        for (int n = 0; n < NCH; n++) g[n*GW +: GW] = GW'(n * 10 + 3);
        load0('1);
        load1(g);
        chk("R6 no latch yet", level, '0);
        pulse_latch();
        chk("R9 full corr passes gray", level, g);
        chk("R5 channel 23 field", B1W'(level[23*GW +: GW]), B1W'(233));
    endtask

    task automatic t_corr();
        logic [B0W-1:0] c;
        for (int n = 0; n < NCH; n++) c[n*CW +: CW] = CW'((n * 7 + 1) % 64);
        load0(c);
        // channel 10: corr 71%64=7, gray 103 -> 103*8>>6 = 12
        chk("R5 straddling field ch10", B1W'(level[10*GW +: GW]), B1W'(12));
        chk("R9 weighted levels", level, exp_level());
    endtask

    task automatic t_daisy();
        for (int i = 0; i < 8; i++) begin
            shift_bit(1'b1, i[0]);
            chk("R4 ser_out gray top", B1W'(ser_out), B1W'(m_sout));
        end
        for (int i = 0; i < 6; i++) begin
            shift_bit(1'b0, ~i[1]);
            chk("R4 ser_out corr top", B1W'(ser_out), B1W'(m_sout));
        end
        chk("R6 latch holds during shifts", level, exp_level());
        pulse_latch();
        chk("R3 chains after mixed shifts", level, exp_level());
    endtask

    task automatic t_noedge();
        logic so;
        so = ser_out;
        for (int i = 0; i < 6; i++) begin
            ser_in = i[0]; bank_sel = i[1];
            settle();
        end
        dclk = 1'b1; bank_sel = 1'b1; ser_in = 1'b1;
        m_sout = m_b1[B1W-1]; m_b1 = {m_b1[B1W-2:0], 1'b1};
        settle();
        for (int i = 0; i < 6; i++) begin
            ser_in = i[0]; bank_sel = i[1];
            settle();
        end
        dclk = 1'b0;
        settle();
        chk("R2 single edge ser_out", B1W'(ser_out), B1W'(m_sout));
        pulse_latch();
        chk("R2 levels after level-only toggles", level, exp_level());
        if (so === 1'b0) begin end
    endtask

    task automatic t_oe();
        out_en_n = 1'b1;
        #1;
        chk("R8 disabled blanks", level, '0);
        out_en_n = 1'b0;
        #1;
        chk("R8 enabled shows", level, exp_level());
    endtask

    task automatic t_same();
        logic [B1W-1:0] pre;
        pre = m_b1;
        ser_in = 1'b1; bank_sel = 1'b1;
        latch_n = 1'b0; dclk = 1'b1;
        m_lat = pre;
        m_b1 = {m_b1[B1W-2:0], 1'b1};
        settle();
        latch_n = 1'b1; dclk = 1'b0;
        settle();
        chk("R7 latch takes pre-shift gray", level, exp_level());
        pulse_latch();
        chk("R7 later latch sees shifted gray", level, exp_level());
    endtask

    task automatic t_pin_rst();
        chip_rst_n = 1'b0;
        settle();
        chk("R1 pin reset ser_out", B1W'(ser_out), '0);
        chk("R1 pin reset levels", level, '0);
        chip_rst_n = 1'b1;
        settle();
        m_b0 = '0; m_b1 = '0; m_lat = '0;
        load0('1);
        pulse_latch();
        chk("R1 gray chain cleared", level, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_load_latch();
        t_corr();
        t_daisy();
        t_noedge();
        t_oe();
        t_same();
        t_pin_rst();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule